// File: doc/BRIEF.md
# Banked Dual-Request Local Word Store

This block is a small on-chip store of 8 rows by 4 columns of 32-bit words, served by two request ports that may both present an access in the same cycle. The storage is divided into independently addressed banks. A compile-time parameter picks how: one bank for everything, one bank per row, or one bank per column. Each incoming row and column pair is turned into a bank number and a word offset inside that bank. Two requests that land in different banks are both carried out in the same clock cycle.

When both ports target the same bank, the block services them one after the other and holds the requesters back for one cycle. The back-pressure rule is plain: while `req_stall` is high, both requesters must keep every request input unchanged. Port 0 is served in the stalled cycle and port 1 in the following cycle, after which `req_stall` is low and new requests may be presented. A request with `valid` low is never served and never causes a stall. Reads return their word one cycle after they are served, each port with its own data bus and valid flag. Stored words are not cleared by reset.

Top module: `banked_lmem`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_stall`, `q0_rvalid` and `q1_rvalid` are low.
- R2: A read served at a clock edge raises that port's `rvalid` in the following cycle, with the word most recently written to that row and column.
- R3: Only the low 2 bits of each 4-bit column input are used; a column value of c and of c + 4k address the same word.
- R4: With per-row banking (GEOM = GEO_ROW), the row selects the bank; two valid requests on different rows never stall.
- R5: With per-column banking (GEOM = GEO_COL), the masked column selects the bank; two valid requests on different masked columns never stall.
- R6: With a single bank (GEOM = GEO_SINGLE), every cycle that newly presents two valid requests stalls.
- R7: On a bank conflict `req_stall` is high for exactly one cycle; port 0 is served in that cycle and port 1 in the next, so a read on port 1 returns its `rvalid` two cycles after the stall cycle began.
- R8: When both ports write the same word in one cycle, the word afterwards holds port 1's data.
- R9: A cycle with at most one valid request never raises `req_stall`.
- R10: `rvalid` on a port rises only after that port was valid with its write enable low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| q0_valid | input | 1 | Port 0 request present |
| q0_row | input | 3 | Port 0 row index |
| q0_col | input | 4 | Port 0 column index, low 2 bits used |
| q0_we | input | 1 | Port 0 write (1) or read (0) |
| q0_wdata | input | 32 | Port 0 write word |
| q1_valid | input | 1 | Port 1 request present |
| q1_row | input | 3 | Port 1 row index |
| q1_col | input | 4 | Port 1 column index, low 2 bits used |
| q1_we | input | 1 | Port 1 write (1) or read (0) |
| q1_wdata | input | 32 | Port 1 write word |
| req_stall | output | 1 | Bank conflict; both ports hold their inputs |
| q0_rdata | output | 32 | Port 0 read word |
| q0_rvalid | output | 1 | Port 0 read word valid |
| q1_rdata | output | 32 | Port 1 read word |
| q1_rvalid | output | 1 | Port 1 read word valid |

## Verification
The bound checker watches, on every cycle, that a stall only appears with two valid requests, never lasts two cycles, that requests on distinct banks under the active geometry pass without a stall, that a single bank stalls every fresh pair, and that read-valid flags follow served reads with the right delay. What the word coming back actually is, the ordering of two writes to one word, and the equivalence of masked column values can only be shown by the bench, which keeps its own copy of the array per geometry and runs three instances side by side on the same request stream, repeating a request while any of them stalls.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

  typedef enum logic [1:0] {
    GEO_SINGLE = 2'd0,
    GEO_ROW    = 2'd1,
    GEO_COL    = 2'd2
  } geo_e;

  function automatic int bank_count(geo_e g, int rows, int cols);
    case (g)
      GEO_ROW: return rows;
      GEO_COL: return cols;
      default: return 1;
    endcase
  endfunction

  function automatic int bits_for(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lmem_addr_map.sv
module lmem_addr_map
  import lmem_pkg::*;
#(
  parameter geo_e GEOM = GEO_ROW,
  parameter int   COLS = 4,
  parameter int   RW   = 3,
  parameter int   CW   = 2,
  parameter int   BW   = 3,
  parameter int   OW   = 2
) (
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  output logic [BW-1:0] bank,
  output logic [OW-1:0] off
);

  generate
    if (GEOM == GEO_ROW) begin : g_row
      assign bank = BW'(row);
      assign off  = OW'(col);
    end else if (GEOM == GEO_COL) begin : g_col
      assign bank = BW'(col);
      assign off  = OW'(row);
    end else begin : g_single
      assign bank = '0;
      assign off  = OW'(32'(row) * 32'(COLS) + 32'(col));
    end
  endgenerate

endmodule

// File: rtl/lmem_arbiter.sv
module lmem_arbiter #(
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v0,
  input  logic          v1,
  input  logic [BW-1:0] bank0,
  input  logic [BW-1:0] bank1,
  output logic          gnt0,
  output logic          gnt1,
  output logic          stall
);

  logic second;   // second cycle of a serialized pair
  logic clash;

  assign clash = v0 && v1 && (bank0 == bank1);
  assign stall = clash && !second;
  assign gnt0  = v0 && !second;
  assign gnt1  = v1 && (!clash || second);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) second <= 1'b0;
    else        second <= stall;
  end

endmodule

// File: rtl/lmem_bank.sv
module lmem_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int OW    = 2
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[off] <= wdata;
      else    rdata    <= mem[off];
    end
  end

endmodule

// File: rtl/banked_lmem.sv
module banked_lmem
  import lmem_pkg::*;
#(
  parameter geo_e GEOM  = GEO_ROW,
  parameter int   ROWS  = 8,
  parameter int   COLS  = 4,
  parameter int   DW    = 32,
  parameter int   CIN_W = 4,
  localparam int  RW    = bits_for(ROWS),
  localparam int  CW    = bits_for(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q0_valid,
  input  logic [RW-1:0]    q0_row,
  input  logic [CIN_W-1:0] q0_col,
  input  logic             q0_we,
  input  logic [DW-1:0]    q0_wdata,
  input  logic             q1_valid,
  input  logic [RW-1:0]    q1_row,
  input  logic [CIN_W-1:0] q1_col,
  input  logic             q1_we,
  input  logic [DW-1:0]    q1_wdata,
  output logic             req_stall,
  output logic [DW-1:0]    q0_rdata,
  output logic             q0_rvalid,
  output logic [DW-1:0]    q1_rdata,
  output logic             q1_rvalid
);

  localparam int NB  = bank_count(GEOM, ROWS, COLS);
  localparam int DEP = (ROWS * COLS) / NB;
  localparam int BW  = bits_for(NB);
  localparam int OW  = bits_for(DEP);

  logic [BW-1:0] bk0, bk1, rb0, rb1;
  logic [OW-1:0] of0, of1;
  logic          gnt0, gnt1;
  logic [DW-1:0] bank_q [NB];
  logic          unused_colhi;

  assign unused_colhi = ^{q0_col, q1_col};

  lmem_addr_map #(.GEOM(GEOM), .COLS(COLS), .RW(RW), .CW(CW), .BW(BW), .OW(OW)) u_map0 (
    .row(q0_row), .col(q0_col[CW-1:0]), .bank(bk0), .off(of0)
  );

  lmem_addr_map #(.GEOM(GEOM), .COLS(COLS), .RW(RW), .CW(CW), .BW(BW), .OW(OW)) u_map1 (
    .row(q1_row), .col(q1_col[CW-1:0]), .bank(bk1), .off(of1)
  );

  lmem_arbiter #(.BW(BW)) u_arb (
    .clk(clk), .rst_n(rst_n), .v0(q0_valid), .v1(q1_valid),
    .bank0(bk0), .bank1(bk1), .gnt0(gnt0), .gnt1(gnt1), .stall(req_stall)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic s0, s1;
      assign s0 = gnt0 && (bk0 == BW'(b));
      assign s1 = gnt1 && (bk1 == BW'(b));
      lmem_bank #(.DW(DW), .DEPTH(DEP), .OW(OW)) u_bank (
        .clk  (clk),
        .en   (s0 || s1),
        .we   (s0 ? q0_we    : q1_we),
        .off  (s0 ? of0      : of1),
        .wdata(s0 ? q0_wdata : q1_wdata),
        .rdata(bank_q[b])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0_rvalid <= 1'b0;
      q1_rvalid <= 1'b0;
    end else begin
      q0_rvalid <= gnt0 && !q0_we;
      q1_rvalid <= gnt1 && !q1_we;
    end
  end

  always_ff @(posedge clk) begin
    if (gnt0) rb0 <= bk0;
    if (gnt1) rb1 <= bk1;
  end

  always_comb begin
    q0_rdata = '0;
    q1_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (rb0 == BW'(b)) q0_rdata = bank_q[b];
      if (rb1 == BW'(b)) q1_rdata = bank_q[b];
    end
  end

endmodule

// File: rtl/lmem_checker.sv
module lmem_checker
  import lmem_pkg::*;
#(
  parameter geo_e GEOM  = GEO_ROW,
  parameter int   RW    = 3,
  parameter int   CW    = 2,
  parameter int   CIN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q0_valid,
  input logic [RW-1:0]    q0_row,
  input logic [CIN_W-1:0] q0_col,
  input logic             q0_we,
  input logic             q1_valid,
  input logic [RW-1:0]    q1_row,
  input logic [CIN_W-1:0] q1_col,
  input logic             q1_we,
  input logic             req_stall,
  input logic             q0_rvalid,
  input logic             q1_rvalid
);

  logic unused_idx;
  assign unused_idx = ^{q0_row, q1_row, q0_col, q1_col};

  AST_STALL_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |-> (q0_valid && q1_valid)); // R7

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |=> !req_stall); // R7

  AST_Q1_READ_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_stall && !q1_we) |=> ##1 q1_rvalid); // R7

  AST_Q0_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (q0_valid && !q0_we && !$past(req_stall)) |=> q0_rvalid); // R2

  AST_Q0_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    q0_rvalid |-> $past(q0_valid && !q0_we)); // R10

  AST_Q1_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    q1_rvalid |-> $past(q1_valid && !q1_we)); // R10

  AST_LONE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(q0_valid && q1_valid) |-> !req_stall); // R9

  generate
    if (GEOM == GEO_ROW) begin : g_row
      AST_ROW_SPLIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q0_valid && q1_valid && q0_row != q1_row) |-> !req_stall); // R4
    end else if (GEOM == GEO_COL) begin : g_col
      AST_COL_SPLIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q0_valid && q1_valid && q0_col[CW-1:0] != q1_col[CW-1:0]) |-> !req_stall); // R5
    end else begin : g_single
      AST_SINGLE_ALWAYS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q0_valid && q1_valid && !$past(req_stall)) |-> req_stall); // R6
    end
  endgenerate

endmodule

bind banked_lmem lmem_checker #(.GEOM(GEOM), .RW(RW), .CW(CW), .CIN_W(CIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .q0_valid(q0_valid), .q0_row(q0_row), .q0_col(q0_col), .q0_we(q0_we),
  .q1_valid(q1_valid), .q1_row(q1_row), .q1_col(q1_col), .q1_we(q1_we),
  .req_stall(req_stall), .q0_rvalid(q0_rvalid), .q1_rvalid(q1_rvalid)
);

// File: tb/sim_banked_lmem.sv
`timescale 1ns/1ps
module sim_banked_lmem;
  import lmem_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        v0 = 0, w0 = 0, v1 = 0, w1 = 0;
  logic [2:0]  r0s = 0, r1s = 0;
  logic [3:0]  c0s = 0, c1s = 0;
  logic [31:0] d0s = 0, d1s = 0;

  // index 0: per-row banking, 1: per-column banking, 2: single bank
  logic        st  [3];
  logic        rv0 [3];
  logic        rv1 [3];
  logic [31:0] rd0 [3];
  logic [31:0] rd1 [3];

  banked_lmem #(.GEOM(GEO_ROW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .q0_valid(v0), .q0_row(r0s), .q0_col(c0s), .q0_we(w0), .q0_wdata(d0s),
    .q1_valid(v1), .q1_row(r1s), .q1_col(c1s), .q1_we(w1), .q1_wdata(d1s),
    .req_stall(st[0]), .q0_rdata(rd0[0]), .q0_rvalid(rv0[0]),
    .q1_rdata(rd1[0]), .q1_rvalid(rv1[0]));

  banked_lmem #(.GEOM(GEO_COL)) u1 (
    .clk(clk), .rst_n(rst_n),
    .q0_valid(v0), .q0_row(r0s), .q0_col(c0s), .q0_we(w0), .q0_wdata(d0s),
    .q1_valid(v1), .q1_row(r1s), .q1_col(c1s), .q1_we(w1), .q1_wdata(d1s),
    .req_stall(st[1]), .q0_rdata(rd0[1]), .q0_rvalid(rv0[1]),
    .q1_rdata(rd1[1]), .q1_rvalid(rv1[1]));

  banked_lmem #(.GEOM(GEO_SINGLE)) u2 (
    .clk(clk), .rst_n(rst_n),
    .q0_valid(v0), .q0_row(r0s), .q0_col(c0s), .q0_we(w0), .q0_wdata(d0s),
    .q1_valid(v1), .q1_row(r1s), .q1_col(c1s), .q1_we(w1), .q1_wdata(d1s),
    .req_stall(st[2]), .q0_rdata(rd0[2]), .q0_rvalid(rv0[2]),
    .q1_rdata(rd1[2]), .q1_rvalid(rv1[2]));

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [31:0] mem [3][32];
  bit          ph  [3];

  function automatic int bk(int g, int r, int c);
    if (g == 0) return r;
    if (g == 1) return c & 3;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive after a falling edge, check stall, step model, check reads
  task automatic cyc(input bit a_v, int a_r, int a_c, bit a_w, logic [31:0] a_d,
                     input bit b_v, int b_r, int b_c, bit b_w, logic [31:0] b_d,
                     input string tag, output bit any_st);
    bit es [3];
    bit s0 [3];
    bit s1 [3];
    bit e0v [3];
    bit e1v [3];
    logic [31:0] e0d [3];
    logic [31:0] e1d [3];
    v0 = a_v; r0s = 3'(a_r); c0s = 4'(a_c); w0 = a_w; d0s = a_d;
    v1 = b_v; r1s = 3'(b_r); c1s = 4'(b_c); w1 = b_w; d1s = b_d;
    #1;
    any_st = 0;
    for (int g = 0; g < 3; g++) begin
      bit conf;
      string stag;
      conf = a_v && b_v && (bk(g, a_r, a_c) == bk(g, b_r, b_c));
      es[g] = conf && !ph[g];
      s0[g] = a_v && !ph[g];
      s1[g] = b_v && (!conf || ph[g]);
      if (!(a_v && b_v)) stag = "R9";
      else if (g == 2) stag = "R6";
      else if (conf) stag = "R7";
      else stag = (g == 0) ? "R4" : "R5";
      chk(st[g] == es[g], stag, $sformatf("stall geo%0d", g), 32'(st[g]), 32'(es[g]));
      if (es[g]) any_st = 1;
    end
    @(posedge clk);
    for (int g = 0; g < 3; g++) begin
      int ia, ib;
      ia = a_r * 4 + (a_c & 3);
      ib = b_r * 4 + (b_c & 3);
      e0v[g] = s0[g] && !a_w;
      e1v[g] = s1[g] && !b_w;
      e0d[g] = mem[g][ia];
      e1d[g] = mem[g][ib];
      if (s0[g] && a_w) mem[g][ia] = a_d;
      if (s1[g] && b_w) mem[g][ib] = b_d;
      ph[g] = es[g];
    end
    @(negedge clk);
    for (int g = 0; g < 3; g++) begin
      chk(rv0[g] == e0v[g], "R10", $sformatf("q0 rvalid geo%0d", g), 32'(rv0[g]), 32'(e0v[g]));
      chk(rv1[g] == e1v[g], "R10", $sformatf("q1 rvalid geo%0d", g), 32'(rv1[g]), 32'(e1v[g]));
      if (e0v[g]) chk(rd0[g] === e0d[g], tag, $sformatf("q0 rdata geo%0d", g), rd0[g], e0d[g]);
      if (e1v[g]) chk(rd1[g] === e1d[g], tag, $sformatf("q1 rdata geo%0d", g), rd1[g], e1d[g]);
    end
  endtask

  // a request pair, held while any instance stalls
  task automatic req(input bit a_v, int a_r, int a_c, bit a_w, logic [31:0] a_d,
                     input bit b_v, int b_r, int b_c, bit b_w, logic [31:0] b_d,
                     input string tag);
    bit s;
    cyc(a_v, a_r, a_c, a_w, a_d, b_v, b_r, b_c, b_w, b_d, tag, s);
    while (s) cyc(a_v, a_r, a_c, a_w, a_d, b_v, b_r, b_c, b_w, b_d, tag, s);
  endtask

  function automatic logic [31:0] dv(int k, int salt);
    return 32'(k) * 32'h9E37_79B1 ^ 32'(salt);
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rs;
    for (int g = 0; g < 3; g++) ph[g] = 0;
    repeat (3) @(negedge clk);
    for (int g = 0; g < 3; g++) begin
      chk(st[g] == 0 && rv0[g] == 0 && rv1[g] == 0, "R1", "outputs in reset",
          {st[g], rv0[g], rv1[g]}, 0);
    end
    rst_n = 1'b1;
    #1;
    for (int g = 0; g < 3; g++) begin
      chk(st[g] == 0 && rv0[g] == 0 && rv1[g] == 0, "R1", "outputs after reset",
          {st[g], rv0[g], rv1[g]}, 0);
    end
    @(negedge clk);

    // fill: rows and columns always differ between the two ports
    for (int i = 0; i < 16; i++)
      req(1, i / 4, i % 4, 1, dv(i, 17), 1, 7 - i / 4, 3 - i % 4, 1, dv(31 - i, 17), "R2");

    // same row, different column: row banks clash, column banks do not
    for (int i = 0; i < 32; i++)
      req(1, i / 4, i % 4, 0, 0, 1, i / 4, (i + 1) % 4, 0, 0, "R2");

    // same column, different row: column banks clash
    for (int i = 0; i < 16; i++)
      req(1, i % 8, i / 8, 0, 0, 1, (i + 3) % 8, i / 8, 0, 0, "R2");

    // same word read on both ports
    req(1, 4, 2, 0, 0, 1, 4, 2, 0, 0, "R7");
    // read on one port, write the same word on the other
    req(1, 6, 1, 0, 0, 1, 6, 1, 1, 32'hC0FF_EE01, "R7");
    req(1, 6, 1, 0, 0, 0, 0, 0, 0, 0, "R7");

    // both ports write one word: port 1 wins
    req(1, 2, 1, 1, 32'h1111_1111, 1, 2, 1, 1, 32'h2222_2222, "R8");
    req(1, 2, 1, 0, 0, 1, 3, 3, 0, 0, "R8");

    // upper column bits are ignored
    req(1, 5, 14, 1, 32'h5A5A_0E0E, 0, 0, 0, 0, 0, "R3");
    req(1, 5, 2, 0, 0, 1, 6, 11, 0, 0, "R3");
    req(1, 0, 7, 0, 0, 1, 0, 15, 0, 0, "R3");

    // lone requests on either port
    req(1, 1, 1, 0, 0, 0, 1, 1, 0, 0, "R9");
    req(0, 1, 1, 0, 0, 1, 7, 0, 0, 0, "R9");
    req(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");

    // mixed traffic
    rs = 32'h2468_ACE1;
    for (int i = 0; i < 300; i++) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      req(rs[0], int'(rs[4:2]), int'(rs[8:5]), rs[9], dv(i, 91),
          rs[10], int'(rs[13:11]), int'(rs[17:14]), rs[18], dv(i, 53), "R2");
    end
    req(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule